// File: doc/BRIEF.md
# GPIO Port with Interrupt Controller

A 32-pin general-purpose I/O port controlled through a small memory-mapped register bus. Software picks each pin's direction and output level, reads the synchronized pad levels, and sets up per-pin interrupt detection. A pin can trigger on a low level, a high level, a rising edge or a falling edge. An override makes it trigger on both edges instead.

Detected events latch into a status register that software clears by writing ones. A mask register gates the latched status onto two combined interrupt lines. One line serves pins 0 to 15 and the other serves pins 16 to 31. Pad inputs pass through a two-flop synchronizer before any sampling or detection. A pad change therefore shows up in the status register on the third rising clock edge after it happens.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads zero, pad_oe_o and pad_o are zero, and both interrupt outputs are low.
- R2: Offset 0x00 is the output data register and offset 0x04 is the direction register, both read/write. pad_o follows the data register. A direction bit of 1 makes that pin an output (pad_oe_o bit = 1).
- R3: Offset 0x08 is read-only and returns pad_i after a two-flop synchronizer. Writes to it are ignored.
- R4: Each pin has a 2-bit trigger field. Pins 0–15 sit in the register at 0x0C and pins 16–31 in the register at 0x10, with pin n at bits [2*(n mod 16)+1 : 2*(n mod 16)]. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R5: When a pin's bit in the edge-select register (0x1C) is 1, its trigger field is ignored and both rising and falling edges set its status bit.
- R6: In the status register (0x18), writing 1 clears a bit and writing 0 leaves it alone. A detection in the same cycle as a clear wins, so a held level trigger stays set until the level goes away.
- R7: Status bits latch whatever the mask register (0x14) holds.
- R8: irq_lo_o is the OR over pins 0–15 of status AND mask. irq_hi_o is the same over pins 16–31.
- R9: A write takes effect on the edge where wr_en_i is high. Read data is valid in the cycle after rd_en_i and is zero otherwise. Offsets other than the eight defined ones read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Read request; data valid the next cycle |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| pad_i | input | 32 | Pad input levels (asynchronous) |
| pad_o | output | 32 | Output levels to the pads |
| pad_oe_o | output | 32 | Output enables to the pads |
| irq_lo_o | output | 1 | Combined interrupt, pins 0–15 |
| irq_hi_o | output | 1 | Combined interrupt, pins 16–31 |

## Verification
The bench runs mixed pad transitions against rising triggers in the lower half and falling triggers in the upper half. A design that swapped the edge polarity, or decoded the wrong configuration register for a half, would latch the wrong pins in status.

It clears a high-level trigger while the level is still held. A design that let the clear win would drop the bit too early. It also writes zeros to status, and a design that did not treat zeros as no-ops would lose pending bits.

The edge-select pin is set up with a low-level code while its pad is low. A design that did not honour the override would latch at once. The same pin must then latch on both edges.

Masking one pin in each half checks that the two interrupt lines stay apart. Access to an undefined offset must read zero and must leave the data register untouched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_DATA = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_PAD  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CFGL = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CFGH = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_BOTH = 8'h1C;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic [NPIN-1:0]   cur_i,
  input  logic [NPIN-1:0]   prev_i,
  input  logic [2*NPIN-1:0] cfg_i,
  input  logic [NPIN-1:0]   both_i,
  output logic [NPIN-1:0]   hit_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    trig_e code;
    logic  rise, fall;
    assign code = trig_e'(cfg_i[2*i +: 2]);
    assign rise = cur_i[i] & ~prev_i[i];
    assign fall = ~cur_i[i] & prev_i[i];

    always_comb begin
      if (both_i[i]) hit_o[i] = rise | fall;
      else begin
        unique case (code)
          TRIG_LOW:  hit_o[i] = ~cur_i[i];
          TRIG_HIGH: hit_o[i] = cur_i[i];
          TRIG_RISE: hit_o[i] = rise;
          TRIG_FALL: hit_o[i] = fall;
          default:   hit_o[i] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [NPIN-1:0]   pad_i,
  output logic [NPIN-1:0]   pad_o,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int unsigned HALF = NPIN / 2;

  logic [NPIN-1:0] data_q, dir_q, mask_q, stat_q, both_q, prev_q;
  logic [NPIN-1:0] cfgl_q, cfgh_q;
  logic [NPIN-1:0] pad_s, hit, clr_req;

  gpio_sync #(.WIDTH(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pad_i),
    .sync_o (pad_s)
  );

  gpio_trig_detect #(.NPIN(NPIN)) u_detect (
    .cur_i (pad_s),
    .prev_i(prev_q),
    .cfg_i ({cfgh_q, cfgl_q}),
    .both_i(both_q),
    .hit_o (hit)
  );

  assign clr_req = (wr_en_i && addr_i == OFF_STAT) ? wdata_i[NPIN-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      cfgl_q <= '0;
      cfgh_q <= '0;
      mask_q <= '0;
      both_q <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pad_s;
      // detection wins over a same-cycle clear
      stat_q <= (stat_q & ~clr_req) | hit;
      if (wr_en_i) begin
        unique case (addr_i)
          OFF_DATA: data_q <= wdata_i[NPIN-1:0];
          OFF_DIR:  dir_q  <= wdata_i[NPIN-1:0];
          OFF_CFGL: cfgl_q <= wdata_i[NPIN-1:0];
          OFF_CFGH: cfgh_q <= wdata_i[NPIN-1:0];
          OFF_MASK: mask_q <= wdata_i[NPIN-1:0];
          OFF_BOTH: both_q <= wdata_i[NPIN-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_en_i) begin
      unique case (addr_i)
        OFF_DATA: rdata_o <= data_q;
        OFF_DIR:  rdata_o <= dir_q;
        OFF_PAD:  rdata_o <= pad_s;
        OFF_CFGL: rdata_o <= cfgl_q;
        OFF_CFGH: rdata_o <= cfgh_q;
        OFF_MASK: rdata_o <= mask_q;
        OFF_STAT: rdata_o <= stat_q;
        OFF_BOTH: rdata_o <= both_q;
        default:  rdata_o <= '0;
      endcase
    end else rdata_o <= '0;
  end

  assign pad_o    = data_q;
  assign pad_oe_o = dir_q;
  assign irq_lo_o = |(stat_q[HALF-1:0] & mask_q[HALF-1:0]);
  assign irq_hi_o = |(stat_q[NPIN-1:HALF] & mask_q[NPIN-1:HALF]);

  // R6
  stat_clear_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~stat_q & $past(stat_q)) & ~$past(clr_req)) == '0);

  // R2
  dir_write_to_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DIR) |=> (pad_oe_o == $past(wdata_i[NPIN-1:0])));

  // R9
  undef_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i > OFF_BOTH) |=> (rdata_o == '0));

  // R8
  irq_lo_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o |-> (|mask_q[HALF-1:0]));

  // R8
  irq_hi_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> (|mask_q[NPIN-1:HALF]));
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pad_in, pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // {pad value, expected status}; low half rising, high half falling
  localparam logic [63:0] VECS [4] = '{
    {32'hFFFF_0000, 32'h0000_0000},
    {32'h0000_FFFF, 32'hFFFF_FFFF},
    {32'h00FF_00F0, 32'h0000_0000},
    {32'h000F_0F0F, 32'h00F0_0F0F}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic set_pad(input logic [31:0] p);
    @(negedge clk); pad_in = p;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    pad_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_o", pad_out, 32'h0);
    check("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);
    rd(8'h04, v); check("R1 dir reg", v, 32'h0);
    rd(8'h14, v); check("R1 mask reg", v, 32'h0);

    // R4 config: low half rising, high half falling
    wr(8'h0C, 32'hAAAA_AAAA);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R4 cfg readback", v, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, v); check("R6 cleared", v, 32'h0);

    // R4 R7 vector walk (mask zero)
    for (int i = 0; i < 4; i++) begin
      set_pad(VECS[i][63:32]);
      rd(8'h18, v); check("R4 R7 vector status", v, VECS[i][31:0]);
      check("R8 masked irq", {30'h0, irq_hi, irq_lo}, 32'h0);
      wr(8'h18, 32'hFFFF_FFFF);
    end

    // R4 R6 high-level trigger on pin 3
    set_pad(32'h0);
    wr(8'h0C, 32'hAAAA_AA6A);
    wr(8'h18, 32'hFFFF_FFFF);
    set_pad(32'h0000_0008);
    rd(8'h18, v); check("R4 high level set", v, 32'h0000_0008);
    wr(8'h18, 32'h0000_0008);
    rd(8'h18, v); check("R6 level holds over clear", v, 32'h0000_0008);
    wr(8'h18, 32'h0);
    rd(8'h18, v); check("R6 zero write no effect", v, 32'h0000_0008);
    wr(8'h14, 32'h0000_0008);
    check("R8 irq lo only", {30'h0, irq_hi, irq_lo}, 32'h1);
    set_pad(32'h0);
    wr(8'h18, 32'h0000_0008);
    rd(8'h18, v); check("R6 cleared after level gone", v, 32'h0);
    check("R8 irq lo drops", {31'h0, irq_lo}, 32'h0);

    // R5 both-edge override on pin 20, field set to low level
    wr(8'h1C, 32'h0010_0000);
    wr(8'h10, 32'hFFFF_FCFF);
    wr(8'h18, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    rd(8'h18, v); check("R5 level code ignored", v, 32'h0);
    set_pad(32'h0010_0000);
    rd(8'h18, v); check("R5 rising edge", v, 32'h0010_0000);
    wr(8'h18, 32'hFFFF_FFFF);
    set_pad(32'h0);
    rd(8'h18, v); check("R5 falling edge", v, 32'h0010_0000);
    wr(8'h14, 32'h0010_0000);
    check("R8 irq hi only", {30'h0, irq_hi, irq_lo}, 32'h2);
    wr(8'h18, 32'h0010_0000);
    check("R8 irq hi drops", {31'h0, irq_hi}, 32'h0);

    // R2 data and direction
    wr(8'h00, 32'hA5A5_0000);
    wr(8'h04, 32'hFFFF_00FF);
    check("R2 pad_o", pad_out, 32'hA5A5_0000);
    check("R2 pad_oe", pad_oe, 32'hFFFF_00FF);
    rd(8'h00, v); check("R2 data readback", v, 32'hA5A5_0000);

    // R3 pad sample, read only
    set_pad(32'h1234_5678);
    rd(8'h08, v); check("R3 pad sample", v, 32'h1234_5678);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R3 write ignored", v, 32'h1234_5678);

    // R9 undefined offset and idle read data
    wr(8'h20, 32'hDEAD_BEEF);
    rd(8'h20, v); check("R9 undefined reads zero", v, 32'h0);
    rd(8'h00, v); check("R9 undefined write ignored", v, 32'hA5A5_0000);
    @(negedge clk); check("R9 idle rdata zero", rdata, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule